// File: doc/BRIEF.md
# Floating-Point Register Stack Controller

This block manages the eight-entry register stack of an x87-style floating-point unit. It holds a rotating top-of-stack pointer, one valid tag for each physical register, and the 80-bit extended-precision contents. Each operation is a two-byte register-form opcode: an escape byte followed by a ModRM-style byte. Stack-relative operand ST(n) lives in physical register (top + n) mod 8.

Pointer moves, tag frees, register pushes, constant pushes, initialize and no-op complete in a single cycle. The multiply-and-pop and divide-and-pop forms work differently. The block presents both operands and an operation code to an external arithmetic datapath, then waits for a result strobe. The write to ST(n) and the pop happen together when the result arrives.

A push into an occupied register, or a read of an empty one, is refused. The block raises a fault flag and leaves all state untouched.

Top module: `fp_stack_ctrl`

## Requirements
- R1: After reset the top pointer is 0, every tag is empty (tag_o = 0), and busy_o, done_o and fault_o are low.
- R2: rd_data_o returns ST(rd_idx_i), which is held in physical register (top_o + rd_idx_i) mod 8. Bit i of tag_o is 1 when physical register i holds a value.
- R3: Opcode D9 F6 decrements the top pointer and D9 F7 increments it, both modulo 8. Neither one changes the tags or the register contents.
- R4: Opcode DD C0+n clears the tag of ST(n). The top pointer and the register contents are unchanged.
- R5: Opcode D9 C0+n pushes a copy of ST(n), where ST(n) is taken relative to the pointer before the push. A push decrements the top pointer modulo 8, writes the new ST(0) and sets its tag.
- R6: Opcodes D9 E8 through D9 EE each push one extended-precision constant. The order is 1.0, log2(10), log2(e), pi, log10(2), ln(2) and +0.0. Each constant has a 16-bit sign/exponent field above a 64-bit mantissa with an explicit integer bit.
- R7: Opcode DB E3 sets the top pointer to 0 and every tag to empty. Opcode D9 D0 and any opcode not listed in these requirements change no state.
- R8: A single-cycle operation is accepted at the clock edge where op_valid_i is high and busy_o is low. Its new state and a one-cycle done_o pulse are visible in the following cycle.
- R9: Opcode DE C8+n raises busy_o and alu_req_o, with alu_op_o = 1 (multiply), alu_a_o = ST(n) and alu_b_o = ST(0). At the edge where alu_res_valid_i is high, alu_res_i is written to ST(n) and the stack pops: the ST(0) tag is cleared and the top pointer is incremented. done_o follows in the next cycle.
- R10: Opcode DE F8+n requests alu_op_o = 2 (divide, alu_a_o / alu_b_o) with alu_a_o = ST(n) and alu_b_o = ST(0). Opcode DE F0+n requests the same code with the operands reversed: alu_a_o = ST(0) and alu_b_o = ST(n). Both complete as in R9.
- R11: A push whose destination tag is set, or an operation that reads an empty ST(n) or ST(0), changes no state. It produces done_o together with fault_o, and starts no arithmetic request.
- R12: While busy_o is high, op_valid_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_valid_i | input | 1 | Opcode present |
| op_esc_i | input | 8 | Escape byte |
| op_modrm_i | input | 8 | Second opcode byte |
| rd_idx_i | input | 3 | Stack-relative index for the observation port |
| rd_data_o | output | 80 | Contents of ST(rd_idx_i) |
| top_o | output | 3 | Top-of-stack pointer |
| tag_o | output | 8 | Valid tag for each physical register |
| busy_o | output | 1 | Waiting for an arithmetic result |
| done_o | output | 1 | Operation completed in the previous cycle |
| fault_o | output | 1 | Completed operation was refused as a stack fault |
| alu_req_o | output | 1 | Arithmetic request pending |
| alu_op_o | output | 2 | 1 multiply, 2 divide (a / b), 0 idle |
| alu_a_o | output | 80 | First operand |
| alu_b_o | output | 80 | Second operand |
| alu_res_valid_i | input | 1 | Result strobe |
| alu_res_i | input | 80 | Arithmetic result |

## Verification
The assertions check the following on every cycle:
- the state freezes while a request is pending and across a fault;
- faults only ever occur together with a completion;
- the operands stay steady during a request;
- a result causes exactly one pop;
- initialize, the pointer moves and the no-op land on the right pointer and tags.

Only the bench scenarios can show the data-dependent behaviour:
- which physical register a stack-relative push copies from;
- the exact constant values;
- the operand order of the reversed divide;
- that the result ends up in ST(n) rather than elsewhere.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int unsigned FP_W = 80;

  typedef enum logic [2:0] {
    K_NOP, K_FLD, K_CONST, K_FREE, K_INC, K_DEC, K_INIT, K_ARITH
  } kind_e;

  typedef enum logic [1:0] {
    AOP_NONE = 2'd0,
    AOP_MUL  = 2'd1,
    AOP_DIV  = 2'd2
  } aop_e;

  typedef struct packed {
    kind_e      kind;
    logic [2:0] idx;
    aop_e       aop;
    logic       rev;
    logic [2:0] csel;
  } dec_t;
endpackage

// File: rtl/fps_decode.sv
module fps_decode
  import fps_pkg::*;
(
  input  logic [7:0] esc_i,
  input  logic [7:0] modrm_i,
  output dec_t       dec_o
);
  always_comb begin
    dec_o      = '0;
    dec_o.kind = K_NOP;
    dec_o.aop  = AOP_NONE;
    dec_o.idx  = modrm_i[2:0];
    dec_o.csel = modrm_i[2:0];
    unique case (esc_i)
      8'hD9: begin
        if (modrm_i[7:3] == 5'b11000) dec_o.kind = K_FLD;
        else if (modrm_i >= 8'hE8 && modrm_i <= 8'hEE) dec_o.kind = K_CONST;
        else if (modrm_i == 8'hF6) dec_o.kind = K_DEC;
        else if (modrm_i == 8'hF7) dec_o.kind = K_INC;
      end
      8'hDD: if (modrm_i[7:3] == 5'b11000) dec_o.kind = K_FREE;
      8'hDB: if (modrm_i == 8'hE3) dec_o.kind = K_INIT;
      8'hDE: begin
        if (modrm_i[7:3] == 5'b11001) begin
          dec_o.kind = K_ARITH;
          dec_o.aop  = AOP_MUL;
        end else if (modrm_i[7:4] == 4'hF) begin
          // F0-F7: TOS / ST(n); F8-FF: ST(n) / TOS
          dec_o.kind = K_ARITH;
          dec_o.aop  = AOP_DIV;
          dec_o.rev  = ~modrm_i[3];
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/fps_const.sv
module fps_const
  import fps_pkg::*;
(
  input  logic [2:0]      sel_i,
  output logic [FP_W-1:0] val_o
);
  always_comb begin
    unique case (sel_i)
      3'd0:    val_o = {16'h3FFF, 64'h8000_0000_0000_0000}; // 1.0
      3'd1:    val_o = {16'h4000, 64'hD49A_784B_CD1B_8AFE}; // log2(10)
      3'd2:    val_o = {16'h3FFF, 64'hB8AA_3B29_5C17_F0BC}; // log2(e)
      3'd3:    val_o = {16'h4000, 64'hC90F_DAA2_2168_C235}; // pi
      3'd4:    val_o = {16'h3FFD, 64'h9A20_9A84_FBCF_F799}; // log10(2)
      3'd5:    val_o = {16'h3FFE, 64'hB172_17F7_D1CF_79AC}; // ln(2)
      default: val_o = '0;                                  // +0.0
    endcase
  end
endmodule

// File: rtl/fps_regfile.sv
module fps_regfile #(
  parameter int unsigned NREG  = 8,
  parameter int unsigned WIDTH = 80,
  localparam int unsigned AW   = $clog2(NREG)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic [AW-1:0]    ra_a_i,
  output logic [WIDTH-1:0] rd_a_o,
  input  logic [AW-1:0]    ra_b_i,
  output logic [WIDTH-1:0] rd_b_o,
  input  logic [AW-1:0]    ra_c_i,
  output logic [WIDTH-1:0] rd_c_o
);
  logic [WIDTH-1:0] mem_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                            mem_q[i] <= '0;
      else if (we_i && waddr_i == AW'(i))     mem_q[i] <= wdata_i;
    end
  end

  assign rd_a_o = mem_q[ra_a_i];
  assign rd_b_o = mem_q[ra_b_i];
  assign rd_c_o = mem_q[ra_c_i];
endmodule

// File: rtl/fp_stack_ctrl.sv
module fp_stack_ctrl
  import fps_pkg::*;
#(
  parameter int unsigned NREG = 8,
  localparam int unsigned PW  = $clog2(NREG)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            op_valid_i,
  input  logic [7:0]      op_esc_i,
  input  logic [7:0]      op_modrm_i,
  input  logic [PW-1:0]   rd_idx_i,
  output logic [FP_W-1:0] rd_data_o,
  output logic [PW-1:0]   top_o,
  output logic [NREG-1:0] tag_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            fault_o,
  output logic            alu_req_o,
  output logic [1:0]      alu_op_o,
  output logic [FP_W-1:0] alu_a_o,
  output logic [FP_W-1:0] alu_b_o,
  input  logic            alu_res_valid_i,
  input  logic [FP_W-1:0] alu_res_i
);
  localparam logic [PW-1:0] ONE = PW'(1);

  dec_t dec;
  logic [PW-1:0]   top_q, top_d, tgt_q, tgt_d;
  logic [NREG-1:0] tag_q, tag_d;
  logic            busy_q, busy_d, done_q, done_d, fault_q, fault_d;
  aop_e            aop_q, aop_d;
  logic            rev_q, rev_d;
  logic [PW-1:0]   src_idx, push_idx, ra_a;
  logic            we;
  logic [PW-1:0]   waddr;
  logic [FP_W-1:0] wdata, rd_a, rd_tos, cval;

  fps_decode i_dec (.esc_i(op_esc_i), .modrm_i(op_modrm_i), .dec_o(dec));
  fps_const  i_const (.sel_i(dec.csel), .val_o(cval));

  assign src_idx  = top_q + PW'(dec.idx);
  assign push_idx = top_q - ONE;
  assign ra_a     = busy_q ? tgt_q : src_idx;

  fps_regfile #(.NREG(NREG), .WIDTH(FP_W)) i_rf (
    .clk_i, .rst_ni,
    .we_i(we), .waddr_i(waddr), .wdata_i(wdata),
    .ra_a_i(ra_a),             .rd_a_o(rd_a),
    .ra_b_i(top_q),            .rd_b_o(rd_tos),
    .ra_c_i(top_q + rd_idx_i), .rd_c_o(rd_data_o)
  );

  always_comb begin
    top_d   = top_q;
    tag_d   = tag_q;
    busy_d  = busy_q;
    tgt_d   = tgt_q;
    aop_d   = aop_q;
    rev_d   = rev_q;
    done_d  = 1'b0;
    fault_d = 1'b0;
    we      = 1'b0;
    waddr   = push_idx;
    wdata   = cval;
    if (busy_q) begin
      if (alu_res_valid_i) begin
        we            = 1'b1;
        waddr         = tgt_q;
        wdata         = alu_res_i;
        tag_d[top_q]  = 1'b0;
        top_d         = top_q + ONE;
        busy_d        = 1'b0;
        done_d        = 1'b1;
      end
    end else if (op_valid_i) begin
      done_d = 1'b1;
      unique case (dec.kind)
        K_FLD: begin
          if (!tag_q[src_idx] || tag_q[push_idx]) fault_d = 1'b1;
          else begin
            we              = 1'b1;
            wdata           = rd_a;
            tag_d[push_idx] = 1'b1;
            top_d           = push_idx;
          end
        end
        K_CONST: begin
          if (tag_q[push_idx]) fault_d = 1'b1;
          else begin
            we              = 1'b1;
            tag_d[push_idx] = 1'b1;
            top_d           = push_idx;
          end
        end
        K_FREE: tag_d[src_idx] = 1'b0;
        K_INC:  top_d = top_q + ONE;
        K_DEC:  top_d = top_q - ONE;
        K_INIT: begin
          top_d = '0;
          tag_d = '0;
        end
        K_ARITH: begin
          if (!tag_q[src_idx] || !tag_q[top_q]) fault_d = 1'b1;
          else begin
            busy_d = 1'b1;
            done_d = 1'b0;
            tgt_d  = src_idx;
            aop_d  = dec.aop;
            rev_d  = dec.rev;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      top_q   <= '0;
      tag_q   <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      tgt_q   <= '0;
      aop_q   <= AOP_NONE;
      rev_q   <= 1'b0;
    end else begin
      top_q   <= top_d;
      tag_q   <= tag_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
      fault_q <= fault_d;
      tgt_q   <= tgt_d;
      aop_q   <= aop_d;
      rev_q   <= rev_d;
    end
  end

  assign top_o     = top_q;
  assign tag_o     = tag_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign fault_o   = fault_q;
  assign alu_req_o = busy_q;
  assign alu_op_o  = busy_q ? aop_q : AOP_NONE;
  assign alu_a_o   = rev_q ? rd_tos : rd_a;
  assign alu_b_o   = rev_q ? rd_a : rd_tos;
endmodule

// File: rtl/fps_checker.sv
module fps_checker #(
  parameter int unsigned NREG = 8,
  localparam int unsigned PW  = $clog2(NREG)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            op_valid_i,
  input logic [7:0]      op_esc_i,
  input logic [7:0]      op_modrm_i,
  input logic [PW-1:0]   top_o,
  input logic [NREG-1:0] tag_o,
  input logic            busy_o,
  input logic            done_o,
  input logic            fault_o,
  input logic            alu_req_o,
  input logic [1:0]      alu_op_o,
  input logic [79:0]     alu_a_o,
  input logic [79:0]     alu_b_o,
  input logic            alu_res_valid_i
);
  logic acc;
  assign acc = op_valid_i && !busy_o;

  p_wait_frozen_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !alu_res_valid_i |=> $stable(top_o) && $stable(tag_o) && !done_o);

  p_fault_no_change_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> done_o && !busy_o && top_o == $past(top_o) && tag_o == $past(tag_o));

  p_operands_steady_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_req_o && !alu_res_valid_i |=> !alu_req_o || ($stable(alu_a_o) && $stable(alu_b_o) && $stable(alu_op_o)));

  p_result_pops_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_req_o && alu_res_valid_i |=> top_o == PW'($past(top_o) + 1) && done_o && !busy_o
      && !tag_o[$past(top_o)]);

  p_init_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_esc_i == 8'hDB && op_modrm_i == 8'hE3 |=> top_o == '0 && tag_o == '0 && done_o);

  p_nop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_esc_i == 8'hD9 && op_modrm_i == 8'hD0 |=> $stable(top_o) && $stable(tag_o) && done_o);

  p_inc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_esc_i == 8'hD9 && op_modrm_i == 8'hF7 |=> top_o == PW'($past(top_o) + 1) && $stable(tag_o));

  p_dec_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc && op_esc_i == 8'hD9 && op_modrm_i == 8'hF6 |=> top_o == PW'($past(top_o) - 1) && $stable(tag_o));

  p_req_matches_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alu_req_o |-> busy_o && alu_op_o != 2'd0);
endmodule

bind fp_stack_ctrl fps_checker #(.NREG(NREG)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .op_valid_i(op_valid_i), .op_esc_i(op_esc_i),
  .op_modrm_i(op_modrm_i), .top_o(top_o), .tag_o(tag_o), .busy_o(busy_o),
  .done_o(done_o), .fault_o(fault_o), .alu_req_o(alu_req_o), .alu_op_o(alu_op_o),
  .alu_a_o(alu_a_o), .alu_b_o(alu_b_o), .alu_res_valid_i(alu_res_valid_i)
);

// File: tb/test_fp_stack_ctrl.sv
module test_fp_stack_ctrl;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0, rst_ni = 1'b0;
  logic        op_valid_i = 1'b0;
  logic [7:0]  op_esc_i = '0, op_modrm_i = '0;
  logic [2:0]  rd_idx_i = '0;
  logic [79:0] rd_data_o, alu_a_o, alu_b_o, alu_res_i = '0;
  logic [2:0]  top_o;
  logic [7:0]  tag_o;
  logic        busy_o, done_o, fault_o, alu_req_o, alu_res_valid_i = 1'b0;
  logic [1:0]  alu_op_o;

  int n_chk = 0, n_err = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fp_stack_ctrl i_fp_stack_ctrl (
    .clk_i(clk), .rst_ni, .op_valid_i, .op_esc_i, .op_modrm_i, .rd_idx_i,
    .rd_data_o, .top_o, .tag_o, .busy_o, .done_o, .fault_o, .alu_req_o,
    .alu_op_o, .alu_a_o, .alu_b_o, .alu_res_valid_i, .alu_res_i
  );

  typedef struct packed {
    logic [7:0] esc;
    logic [7:0] modrm;
    logic [2:0] top;
    logic [7:0] tag;
    logic       flt;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{8'hD9, 8'hE8, 3'd7, 8'h80, 1'b0},  // R6 push 1.0
    '{8'hD9, 8'hEB, 3'd6, 8'hC0, 1'b0},  // R6 push pi
    '{8'hD9, 8'hC1, 3'd5, 8'hE0, 1'b0},  // R5 copy ST(1)
    '{8'hD9, 8'hF6, 3'd4, 8'hE0, 1'b0},  // R3 dec
    '{8'hD9, 8'hF7, 3'd5, 8'hE0, 1'b0},  // R3 inc
    '{8'hD9, 8'hD0, 3'd5, 8'hE0, 1'b0},  // R7 nop
    '{8'hDD, 8'hC1, 3'd5, 8'hA0, 1'b0},  // R4 free ST(1)=phys6
    '{8'hD9, 8'hC1, 3'd5, 8'hA0, 1'b1},  // R11 read empty
    '{8'hD9, 8'hF7, 3'd6, 8'hA0, 1'b0},  // R3 inc
    '{8'hD9, 8'hEE, 3'd6, 8'hA0, 1'b1},  // R11 push onto full phys5
    '{8'hD9, 8'hF6, 3'd5, 8'hA0, 1'b0},  // R3
    '{8'hD9, 8'hF6, 3'd4, 8'hA0, 1'b0},  // R3
    '{8'hD9, 8'hEE, 3'd3, 8'hA8, 1'b0},  // R6 push 0.0
    '{8'h12, 8'h34, 3'd3, 8'hA8, 1'b0}   // R7 unknown opcode
  };

  localparam logic [79:0] C_ONE  = {16'h3FFF, 64'h8000000000000000};
  localparam logic [79:0] C_L2T  = {16'h4000, 64'hD49A784BCD1B8AFE};
  localparam logic [79:0] C_L2E  = {16'h3FFF, 64'hB8AA3B295C17F0BC};
  localparam logic [79:0] C_PI   = {16'h4000, 64'hC90FDAA22168C235};
  localparam logic [79:0] C_LG2  = {16'h3FFD, 64'h9A209A84FBCFF799};
  localparam logic [79:0] C_LN2  = {16'h3FFE, 64'hB17217F7D1CF79AC};
  localparam logic [79:0] CONSTS [7] = '{C_ONE, C_L2T, C_L2E, C_PI, C_LG2, C_LN2, 80'h0};
  localparam logic [79:0] RES1 = 80'h1111_2222_3333_4444_5555;
  localparam logic [79:0] RES2 = 80'hAAAA_BBBB_CCCC_DDDD_EEEE;
  localparam logic [79:0] RES3 = 80'h0F0F_1E1E_2D2D_3C3C_4B4B;

  task automatic chk(input string req, input logic [79:0] act, input logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive at a falling edge; accepted at the next rising edge; sample after it.
  task automatic do_op(input logic [7:0] e, input logic [7:0] m);
    @(negedge clk);
    op_esc_i = e; op_modrm_i = m; op_valid_i = 1'b1;
    @(negedge clk);
    op_valid_i = 1'b0;
  endtask

  task automatic st(input logic [2:0] n, input logic [79:0] exp, input string req);
    rd_idx_i = n;
    #1;
    chk(req, rd_data_o, exp);
  endtask

  task automatic give_result(input logic [79:0] r);
    @(negedge clk);
    alu_res_i = r; alu_res_valid_i = 1'b1;
    @(negedge clk);
    alu_res_valid_i = 1'b0;
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 top", 80'(top_o), 80'd0);
    chk("R1 tag", 80'(tag_o), 80'd0);
    chk("R1 flags", 80'({busy_o, done_o, fault_o, alu_req_o}), 80'd0);
    rst_ni = 1'b1;

    // R8 table walk: state and done pulse one cycle after acceptance
    for (int i = 0; i < NV; i++) begin
      do_op(VECS[i].esc, VECS[i].modrm);
      chk($sformatf("R8 vec%0d top", i), 80'(top_o), 80'(VECS[i].top));
      chk($sformatf("R8 vec%0d tag", i), 80'(tag_o), 80'(VECS[i].tag));
      chk($sformatf("R11 vec%0d done/fault", i), 80'({done_o, fault_o}), 80'({1'b1, VECS[i].flt}));
    end
    @(negedge clk);
    chk("R8 done is a pulse", 80'(done_o), 80'd0);

    // R2/R5/R4 contents: top=3
    st(3'd0, 80'h0, "R2 ST0 zero");
    st(3'd2, C_ONE, "R5 copied value");
    st(3'd3, C_PI,  "R4 free keeps contents");
    st(3'd4, C_ONE, "R2 ST4");

    // R7 init
    do_op(8'hDB, 8'hE3);
    chk("R7 init top", 80'(top_o), 80'd0);
    chk("R7 init tag", 80'(tag_o), 80'd0);

    // R3 wrap below zero
    do_op(8'hD9, 8'hF6);
    chk("R3 dec wrap", 80'(top_o), 80'd7);
    do_op(8'hD9, 8'hF7);
    chk("R3 inc wrap", 80'(top_o), 80'd0);

    // R11 arithmetic on empty registers
    do_op(8'hDE, 8'hC9);
    chk("R11 arith fault", 80'({done_o, fault_o, busy_o, alu_req_o}), 80'b1100);

    // R9 multiply-pop
    do_op(8'hD9, 8'hE8);
    do_op(8'hD9, 8'hEB);
    do_op(8'hDE, 8'hC9);
    chk("R9 busy/req", 80'({busy_o, alu_req_o, done_o}), 80'b110);
    chk("R9 op", 80'(alu_op_o), 80'd1);
    chk("R9 a=ST1", alu_a_o, C_ONE);
    chk("R9 b=TOS", alu_b_o, C_PI);
    do_op(8'hD9, 8'hF7);
    chk("R12 ignored top", 80'(top_o), 80'd6);
    chk("R12 ignored done", 80'(done_o), 80'd0);
    give_result(RES1);
    chk("R9 done", 80'({done_o, fault_o, busy_o}), 80'b100);
    chk("R9 pop top", 80'(top_o), 80'd7);
    chk("R9 pop tag", 80'(tag_o), 80'h80);
    st(3'd0, RES1, "R9 result in ST(n)");

    // R10 reversed divide: TOS / ST(1)
    do_op(8'hD9, 8'hEA);
    do_op(8'hDE, 8'hF1);
    chk("R10 rev op", 80'(alu_op_o), 80'd2);
    chk("R10 rev a=TOS", alu_a_o, C_L2E);
    chk("R10 rev b=ST1", alu_b_o, RES1);
    give_result(RES2);
    chk("R10 rev top", 80'(top_o), 80'd7);
    st(3'd0, RES2, "R10 rev result");

    // R10 forward divide: ST(1) / TOS
    do_op(8'hD9, 8'hED);
    do_op(8'hDE, 8'hF9);
    chk("R10 fwd op", 80'(alu_op_o), 80'd2);
    chk("R10 fwd a=ST1", alu_a_o, RES2);
    chk("R10 fwd b=TOS", alu_b_o, C_LN2);
    give_result(RES3);
    st(3'd0, RES3, "R10 fwd result");

    // R6 all constants, then fill and overflow
    do_op(8'hDB, 8'hE3);
    for (int k = 0; k < 7; k++) do_op(8'hD9, 8'(8'hE8 + k));
    chk("R6 top after 7 pushes", 80'(top_o), 80'd1);
    for (int k = 0; k < 7; k++)
      st(3'(k), CONSTS[6-k], $sformatf("R6 const%0d", 6 - k));
    do_op(8'hD9, 8'hE8);
    chk("R5 eighth push", 80'({top_o, tag_o, fault_o}), 80'({3'd0, 8'hFF, 1'b0}));
    do_op(8'hD9, 8'hC0);
    chk("R11 full stack push", 80'({top_o, tag_o, fault_o}), 80'({3'd0, 8'hFF, 1'b1}));

    finish_run();
  end
endmodule